// File: doc/BRIEF.md
# Serial-In Latched Sink Driver Core

This block is the logic core of a serial-to-parallel output driver. A bit stream enters a shift chain on each rising clock edge and moves one stage per clock toward a serial output. That output lets several of these blocks be chained into a longer chain.

A level-sensitive strobe opens a bank of transparent storage latches, one per stage. While the strobe is high the latches follow the chain. While it is low they keep their last value. An active-low enable passes the stored bits to the sink-control outputs. A 1 at an output means that sink is switched on. Taking the enable high forces every output off and leaves the stored state untouched.

A synchronous reset input stands in for power-on reset. It clears the chain and the latches.

Top module: `serial_sink_driver_core`

## Requirements
- R1: On each rising clock edge with `rst` low, stage 0 (`shift_q[0]`) takes the value of `ser_in`.
- R2: On each rising edge every stage k moves to stage k+1. `ser_out` is the last stage, index STAGES-1, so the first bit shifted in reaches `ser_out` after STAGES edges. `ser_out` changes only after the edge, so a downstream block sampling on that same edge gets the old last-stage value.
- R3: While `strobe` is high, storage bit i follows shift stage i. This includes a shift that happens while the strobe is high.
- R4: While `strobe` is low, the storage bits keep their value even though the chain keeps shifting.
- R5: While `out_en_n` is 1, every bit of `sink_on` is 0, whatever the stored bits are.
- R6: While `out_en_n` is 0, `sink_on[i]` equals storage bit i, and 1 means sink i is on.
- R7: The level of `out_en_n` changes neither the chain nor the storage bits. Data shifted or strobed while outputs are blanked appears unchanged once the outputs are enabled or shifted out.
- R8: While `rst` is high, the storage bits are 0 immediately. After a rising edge with `rst` high, all chain stages are 0. After reset, `sink_on` is 0 and `ser_out` is 0.
- R9: Bypass use: with `strobe` held high and `out_en_n` held 1 during serial entry, `sink_on` stays 0 on every cycle. Once `out_en_n` drops to 0, `sink_on` shows the full shifted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock. The chain advances on the rising edge. |
| rst | input | 1 | Synchronous reset for the chain and level clear for the storage. Active high; models power-on. |
| ser_in | input | 1 | Serial data into stage 0. |
| strobe | input | 1 | High makes the storage transparent; low holds it. |
| out_en_n | input | 1 | Active-low output enable. 1 blanks all outputs. |
| ser_out | output | 1 | Last chain stage, for cascading. |
| sink_on | output | STAGES | Per-output sink control; 1 = on. |

## Verification
A broken chain stage shows up at `ser_out` once the bad bit has walked to the end, at most STAGES edges later. If strobe is high with enable low, it also shows at `sink_on` in the same cycle. A storage bit that leaks while strobe is low changes `sink_on` in the cycle the chain moves, as long as outputs are enabled. An enable that disturbs state is invisible while outputs are blanked. It is exposed when the outputs are enabled again or when the word is shifted out. The bench checks before and after each edge, so a `ser_out` that moves early is caught in the cycle it happens.

// File: rtl/ssd_pkg.sv
package ssd_pkg;
  localparam int unsigned SSD_STAGES = 8;

  typedef enum logic {
    DRIVE_LATCH = 1'b0,
    DRIVE_BLANK = 1'b1
  } drive_sel_e;
endpackage

// File: rtl/ssd_shift_chain.sv
module ssd_shift_chain #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         din,
  output logic [W-1:0] stages,
  output logic         tail
);
  localparam int unsigned LAST = W - 1;

  // stage 0 receives new data, higher indices are closer to the tail
  function automatic logic [W-1:0] advance(input logic [W-1:0] cur, input logic bit_in);
    return {cur[W-2:0], bit_in};
  endfunction

  logic [W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= advance(chain_q, din);
  end

  assign stages = chain_q;
  assign tail   = chain_q[LAST];
endmodule

// File: rtl/ssd_store_latch.sv
module ssd_store_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clr,
  input  logic         open,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_cell
    logic cell_q;
    always_latch begin
      if (clr)       cell_q <= 1'b0;
      else if (open) cell_q <= d[i];
    end
    assign q[i] = cell_q;
  end
endmodule

// File: rtl/ssd_drive_gate.sv
module ssd_drive_gate
  import ssd_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         blank_n,
  input  logic [W-1:0] stored,
  output logic [W-1:0] drive
);
  function automatic logic [W-1:0] gate_word(input drive_sel_e sel, input logic [W-1:0] word);
    return (sel == DRIVE_BLANK) ? '0 : word;
  endfunction

  drive_sel_e sel;

  always_comb begin
    sel   = blank_n ? DRIVE_BLANK : DRIVE_LATCH;
    drive = gate_word(sel, stored);
  end
endmodule

// File: rtl/serial_sink_driver_core.sv
module serial_sink_driver_core #(
  parameter int unsigned STAGES = ssd_pkg::SSD_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_in,
  input  logic              strobe,
  input  logic              out_en_n,
  output logic              ser_out,
  output logic [STAGES-1:0] sink_on
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] latch_q;

  ssd_shift_chain #(.W(STAGES)) u_chain (
    .clk    (clk),
    .rst    (rst),
    .din    (ser_in),
    .stages (shift_q),
    .tail   (ser_out)
  );

  ssd_store_latch #(.W(STAGES)) u_store (
    .clr  (rst),
    .open (strobe),
    .d    (shift_q),
    .q    (latch_q)
  );

  ssd_drive_gate #(.W(STAGES)) u_gate (
    .blank_n (out_en_n),
    .stored  (latch_q),
    .drive   (sink_on)
  );
endmodule

// File: rtl/ssd_checks.sv
module ssd_checks #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         ser_in,
  input logic         strobe,
  input logic         out_en_n,
  input logic         ser_out,
  input logic [W-1:0] sink_on,
  input logic [W-1:0] shift_q,
  input logic [W-1:0] latch_q
);
  assert_stage0_capture_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> shift_q[0] == $past(ser_in));

  assert_stage_advance_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> shift_q[W-1:1] == $past(shift_q[W-2:0]));

  assert_tail_after_edge_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ser_out == $past(shift_q[W-2]));

  assert_open_follows_R3: assert property (@(posedge clk) disable iff (rst)
    strobe |-> latch_q == shift_q);

  assert_closed_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (!strobe && !$past(strobe) && !$past(rst)) |-> $stable(latch_q));

  assert_blank_off_R5: assert property (@(posedge clk) disable iff (rst)
    out_en_n |-> sink_on == '0);

  assert_enabled_drive_R6: assert property (@(posedge clk) disable iff (rst)
    !out_en_n |-> sink_on == latch_q);

  assert_reset_clear_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (shift_q == '0 && latch_q == '0));
endmodule

bind serial_sink_driver_core ssd_checks #(.W(STAGES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ser_in   (ser_in),
  .strobe   (strobe),
  .out_en_n (out_en_n),
  .ser_out  (ser_out),
  .sink_on  (sink_on),
  .shift_q  (shift_q),
  .latch_q  (latch_q)
);

// File: tb/sim_serial_sink_driver_core.sv
module sim_serial_sink_driver_core;
  localparam int N = 8;
  localparam time TCK = 20ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_in = 1'b0;
  logic strobe = 1'b0;
  logic out_en_n = 1'b0;
  logic ser_out;
  logic [N-1:0] sink_on;

  serial_sink_driver_core #(.STAGES(N)) u0 (
    .clk(clk), .rst(rst), .ser_in(ser_in), .strobe(strobe),
    .out_en_n(out_en_n), .ser_out(ser_out), .sink_on(sink_on)
  );

  always #(TCK/2) clk = ~clk;

  typedef struct {
    logic [N-1:0] sink;
    logic         so;
    string        tag;
  } exp_t;

  exp_t   sb_q[$];
  event   chk_ev;
  int     n_vec = 0;
  int     n_bad = 0;
  bit     done  = 1'b0;
  logic [N-1:0] m_sh  = '0;
  logic [N-1:0] m_lat = '0;

  // monitor: pops expected items and compares with the ports
  initial begin
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_vec++;
        if (sink_on !== e.sink || ser_out !== e.so) begin
          n_bad++;
          $display("FAIL %s: sink_on=%b ser_out=%b expected sink_on=%b ser_out=%b",
                   e.tag, sink_on, ser_out, e.sink, e.so);
        end
      end
    end
  end

  task automatic push_exp(input string tag);
    exp_t e;
    e.sink = out_en_n ? '0 : m_lat;
    e.so   = m_sh[N-1];
    e.tag  = tag;
    sb_q.push_back(e);
    ->chk_ev;
    #1;
  endtask

  // one clock: check before and after the rising edge
  task automatic step(input logic d, input logic stb, input logic oen, input string tag);
    @(negedge clk);
    ser_in = d; strobe = stb; out_en_n = oen;
    #1;
    if (stb) m_lat = m_sh;
    push_exp(tag);
    @(posedge clk);
    #1;
    m_sh = {m_sh[N-2:0], d};
    if (stb) m_lat = m_sh;
    push_exp(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; strobe = 1'b0; out_en_n = 1'b0;
    m_lat = '0;
    repeat (2) @(posedge clk);
    m_sh = '0;
    @(negedge clk);
    rst = 1'b0;
    #1;
    push_exp("R8");
  endtask

  task automatic shift_word(input logic [N-1:0] w, input logic stb, input logic oen, input string tag);
    for (int i = N - 1; i >= 0; i--) step(w[i], stb, oen, tag);
  endtask

  initial begin
    do_reset();
    // R1/R4: shift with storage closed, outputs enabled, stay zero
    shift_word(8'hA5, 1'b0, 1'b0, "R4");
    // R3: open storage over one edge
    step(1'b1, 1'b1, 1'b0, "R3");
    // R1/R4: keep shifting closed; outputs frozen
    shift_word(8'h3C, 1'b0, 1'b0, "R1");
    // R5/R7: blanked while strobing new data
    step(1'b0, 1'b1, 1'b1, "R5");
    shift_word(8'h96, 1'b0, 1'b1, "R7");
    // R6/R7: re-enable, stored word must be intact
    step(1'b0, 1'b0, 1'b0, "R6");
    step(1'b1, 1'b0, 1'b0, "R7");
    // R2: drain the chain to ser_out
    shift_word(8'h00, 1'b0, 1'b0, "R2");
    shift_word(8'hC3, 1'b0, 1'b0, "R2");
    // R9: bypass entry, blanked throughout
    shift_word(8'h5A, 1'b1, 1'b1, "R9");
    step(1'b0, 1'b0, 1'b0, "R9");
    step(1'b1, 1'b1, 1'b0, "R6");
    // R8: reset after nonzero state
    do_reset();
    step(1'b0, 1'b0, 1'b0, "R8");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(TCK * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule